// File: doc/BRIEF.md
# Active Video Start Delay Counter

This block marks where active video begins on each line of a video input port. A line begins at the leading edge of horizontal sync. From that edge the block counts a programmable delay in pixels. It then raises a one-clock start strobe and opens an active-data window for a programmable number of pixels.

The pixel clock runs in one of two modes. In single-rate mode one clock equals one pixel. In double-rate mode every pixel spans two clocks, so the delay, which is held in pixels, is counted as twice as many clocks. The delay is nine bits wide. Its low eight bits sit in one register and its top bit sits in a separate extension register, and a small write port loads both. A free-running pixel-phase bit marks which clock of a pixel pair is the first. In double-rate mode, a start that lands on the second clock of a pair is flagged as an alignment error.

Top module: `avs_start_gen`

## Requirements
- R1: After reset the low delay register holds 0x50 and the extension bit holds 0, so the nine-bit delay D is 80. While reset is applied, sav_pulse, active_win and align_err are all 0.
- R2: A write with cfg_addr=0 loads cfg_wdata[7:0] into delay bits [7:0]. A write with cfg_addr=1 loads cfg_wdata[0] into delay bit 8, and the other data bits of that write are ignored.
- R3: Let E be the clock cycle in which the sync edge is seen. In single-rate mode (dbl_mode=0) sav_pulse is high in cycle E+1+D for exactly one clock.
- R4: In double-rate mode (dbl_mode=1) sav_pulse is high in cycle E+1+2*D for exactly one clock.
- R5: With D=0 the pulse is in cycle E+1 in either mode.
- R6: A sync edge is hsync_in moving to its active level. The active level is high when hsync_act_hi=1 and low when hsync_act_hi=0. Hsync leaving its active level starts nothing.
- R7: A sync edge that arrives while a count is running restarts the count from zero. The start pulse of the abandoned line is never issued.
- R8: Register writes, dbl_mode and act_width are sampled only in the sync-edge cycle, so a change made in the middle of a line takes effect only from the next line.
- R9: Let W be the value of act_width and C the clocks per pixel (1 in single-rate mode, 2 in double-rate mode). active_win is high for W*C consecutive cycles, starting in the cycle after the pulse. With W=0 it never rises.
- R10: The pixel-phase bit is 0 in the first cycle after reset and toggles every clock. In double-rate mode, align_err is set in the cycle after a pulse that falls in a cycle where the phase bit is 1. It stays set until the cycle after the next sync edge. In single-rate mode it never rises.
- R11: A sync edge clears active_win from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync |
| hsync_act_hi | input | 1 | 1: sync active high, 0: active low |
| dbl_mode | input | 1 | 1: two clocks per pixel |
| act_width | input | 10 | Active window length in pixels |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0: low delay byte, 1: extension (bit 0 = delay bit 8) |
| cfg_wdata | input | 8 | Write data |
| sav_pulse | output | 1 | One-clock start-of-active-video strobe |
| active_win | output | 1 | Active-data window |
| align_err | output | 1 | Double-rate odd-phase start flag |

## Verification
The start strobe is decoded from registered count state and the live sync edge, with no extra register. It is therefore due in the cycle E+1+D*C itself. The window and the alignment flag each come one register later, so they change in the cycle after the strobe, and the flag clears in the cycle after the next sync edge. The bench drives inputs on the falling clock edge and samples 1 ns after each rising edge. A behavioural model advanced on the same rising edge gives the expected value of all three outputs for that cycle. Directed line runs also measure the latency of the strobe in clocks, and the length of the window, against these formulas.

// File: rtl/avs_pkg.sv
package avs_pkg;

   typedef enum logic {
      CLK_1X = 1'b0,
      CLK_2X = 1'b1
   } clk_mode_e;

endpackage

// File: rtl/avs_sync_det.sv
module avs_sync_det (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_in,
   input  logic act_hi,
   output logic sync_edge,
   output logic phase
);

   logic lvl;
   logic lvl_q;
   logic ph_q;

   // normalise polarity so that 1 always means "sync asserted"
   assign lvl = act_hi ? hsync_in : ~hsync_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         ph_q  <= 1'b0;
      end else begin
         lvl_q <= lvl;
         ph_q  <= ~ph_q;
      end
   end

   assign sync_edge = lvl & ~lvl_q;
   assign phase     = ph_q;

   // R6: an edge needs a deasserted cycle before it
   assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_edge |=> !sync_edge);

endmodule

// File: rtl/avs_cfg_regs.sv
module avs_cfg_regs
   import avs_pkg::*;
#(
   parameter int unsigned LOW_W   = 8,
   parameter int unsigned WID_W   = 10,
   parameter int unsigned LOW_RST = 'h50,
   parameter bit          DBL_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_addr,
   input  logic [LOW_W-1:0] cfg_wdata,
   input  logic             sync_edge,
   input  logic             dbl_req,
   input  logic [WID_W-1:0] width_req,
   output logic [LOW_W:0]   dly_act,
   output clk_mode_e        mode_act,
   output logic [WID_W-1:0] wid_act
);

   localparam int unsigned DLY_W = LOW_W + 1;
   localparam logic [LOW_W-1:0] LOW_INIT = LOW_W'(LOW_RST);

   initial begin
      assert (LOW_W >= 2) else $error("avs_cfg_regs: LOW_W too small");
      assert (LOW_RST < (2 ** LOW_W)) else $error("avs_cfg_regs: LOW_RST does not fit");
   end

   logic [LOW_W-1:0] low_q;
   logic             ext_q;
   logic [DLY_W-1:0] dly_q;
   clk_mode_e        mode_q;
   clk_mode_e        mode_nx;
   logic [WID_W-1:0] wid_q;

   // staging registers, written from the host side at any time
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_q <= LOW_INIT;
         ext_q <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_addr) ext_q <= cfg_wdata[0];
         else          low_q <= cfg_wdata;
      end
   end

   generate
      if (DBL_EN) begin : g_mode_sel
         assign mode_nx = dbl_req ? CLK_2X : CLK_1X;
      end else begin : g_mode_fix
         assign mode_nx = CLK_1X;
      end
   endgenerate

   // line shadow: loaded only on a sync edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly_q  <= {1'b0, LOW_INIT};
         mode_q <= CLK_1X;
         wid_q  <= '0;
      end else if (sync_edge) begin
         dly_q  <= {ext_q, low_q};
         mode_q <= mode_nx;
         wid_q  <= width_req;
      end
   end

   assign dly_act  = dly_q;
   assign mode_act = mode_q;
   assign wid_act  = wid_q;

   // R8: the line configuration moves only across a sync edge
   assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_edge |=> ($stable(dly_act) && $stable(mode_act) && $stable(wid_act)));

endmodule

// File: rtl/avs_delay_cnt.sv
module avs_delay_cnt
   import avs_pkg::*;
#(
   parameter int unsigned DLY_W  = 9,
   parameter bit          DBL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_edge,
   input  logic [DLY_W-1:0] dly_act,
   input  clk_mode_e        mode_act,
   input  logic             phase,
   output logic             sav_pulse,
   output logic             align_err
);

   localparam int unsigned CNT_W = DLY_W + 1;

   initial begin
      assert (DLY_W >= 2) else $error("avs_delay_cnt: DLY_W too small");
   end

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tgt;
   logic             hit;
   logic             err_q;

   generate
      if (DBL_EN) begin : g_dbl
         assign tgt = (mode_act == CLK_2X) ? {dly_act, 1'b0} : {1'b0, dly_act};

         always_ff @(posedge clk) begin
            if (!rst_n)
               err_q <= 1'b0;
            else if (sync_edge)
               err_q <= 1'b0;
            else if (hit && (mode_act == CLK_2X) && phase)
               err_q <= 1'b1;
         end
      end else begin : g_sgl
         assign tgt   = {1'b0, dly_act};
         assign err_q = 1'b0;
      end
   endgenerate

   // a fresh edge wins over a match on the abandoned line
   assign hit = run_q && (cnt_q == tgt) && !sync_edge;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (sync_edge) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end else if (hit) begin
         run_q <= 1'b0;
      end else if (run_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign sav_pulse = hit;
   assign align_err = err_q;

   // R3: strobe is a single clock wide
   assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sav_pulse |=> !sav_pulse);

   // R10: alignment error only follows a double-rate line
   assert_err_dbl_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(align_err) |-> ($past(sav_pulse) && $past(mode_act == CLK_2X)));

endmodule

// File: rtl/avs_window.sv
module avs_window
   import avs_pkg::*;
#(
   parameter int unsigned WID_W  = 10,
   parameter bit          DBL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_edge,
   input  logic             sav_pulse,
   input  clk_mode_e        mode_act,
   input  logic [WID_W-1:0] wid_act,
   output logic             active_win
);

   localparam int unsigned REM_W = WID_W + 1;

   initial begin
      assert (WID_W >= 1) else $error("avs_window: WID_W too small");
   end

   logic [REM_W-1:0] span;
   logic [REM_W-1:0] rem_q;
   logic             on_q;

   generate
      if (DBL_EN) begin : g_dbl
         assign span = (mode_act == CLK_2X) ? {wid_act, 1'b0} : {1'b0, wid_act};
      end else begin : g_sgl
         assign span = {1'b0, wid_act};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_q  <= 1'b0;
         rem_q <= '0;
      end else if (sync_edge) begin
         on_q  <= 1'b0;
      end else if (sav_pulse && (span != '0)) begin
         on_q  <= 1'b1;
         rem_q <= span - 1'b1;
      end else if (on_q) begin
         if (rem_q == '0) on_q  <= 1'b0;
         else             rem_q <= rem_q - 1'b1;
      end
   end

   assign active_win = on_q;

   // R9: the window opens only right after a start strobe
   assert_win_after_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_win) |-> $past(sav_pulse));

   // R11: a new line closes the window
   assert_win_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sync_edge |=> !active_win);

endmodule

// File: rtl/avs_start_gen.sv
module avs_start_gen
   import avs_pkg::*;
#(
   parameter int unsigned LOW_W   = 8,
   parameter int unsigned WID_W   = 10,
   parameter int unsigned LOW_RST = 'h50,
   parameter bit          DBL_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_in,
   input  logic             hsync_act_hi,
   input  logic             dbl_mode,
   input  logic [WID_W-1:0] act_width,
   input  logic             cfg_we,
   input  logic             cfg_addr,
   input  logic [LOW_W-1:0] cfg_wdata,
   output logic             sav_pulse,
   output logic             active_win,
   output logic             align_err
);

   localparam int unsigned DLY_W = LOW_W + 1;

   logic             sync_edge;
   logic             phase;
   logic [DLY_W-1:0] dly_act;
   clk_mode_e        mode_act;
   logic [WID_W-1:0] wid_act;

   avs_sync_det u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .hsync_in  (hsync_in),
      .act_hi    (hsync_act_hi),
      .sync_edge (sync_edge),
      .phase     (phase)
   );

   avs_cfg_regs #(
      .LOW_W   (LOW_W),
      .WID_W   (WID_W),
      .LOW_RST (LOW_RST),
      .DBL_EN  (DBL_EN)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .sync_edge (sync_edge),
      .dbl_req   (dbl_mode),
      .width_req (act_width),
      .dly_act   (dly_act),
      .mode_act  (mode_act),
      .wid_act   (wid_act)
   );

   avs_delay_cnt #(
      .DLY_W  (DLY_W),
      .DBL_EN (DBL_EN)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_edge (sync_edge),
      .dly_act   (dly_act),
      .mode_act  (mode_act),
      .phase     (phase),
      .sav_pulse (sav_pulse),
      .align_err (align_err)
   );

   avs_window #(
      .WID_W  (WID_W),
      .DBL_EN (DBL_EN)
   ) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_edge  (sync_edge),
      .sav_pulse  (sav_pulse),
      .mode_act   (mode_act),
      .wid_act    (wid_act),
      .active_win (active_win)
   );

endmodule

// File: tb/avs_start_gen_tb.sv
`timescale 1ns/1ps
module avs_start_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync_in = 1'b0;
   logic       hsync_act_hi = 1'b1;
   logic       dbl_mode = 1'b0;
   logic [9:0] act_width = '0;
   logic       cfg_we = 1'b0;
   logic       cfg_addr = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       sav_pulse;
   logic       active_win;
   logic       align_err;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   avs_start_gen u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .hsync_in     (hsync_in),
      .hsync_act_hi (hsync_act_hi),
      .dbl_mode     (dbl_mode),
      .act_width    (act_width),
      .cfg_we       (cfg_we),
      .cfg_addr     (cfg_addr),
      .cfg_wdata    (cfg_wdata),
      .sav_pulse    (sav_pulse),
      .active_win   (active_win),
      .align_err    (align_err)
   );

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s got %0d exp %0d", tag, got, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit m_lvl_q, m_ph, m_ext, m_dbl, m_run, m_win, m_err;
   int m_low, m_dly, m_wid, m_cnt, m_rem;

   always @(posedge clk) begin
      bit lvl, edg, pls;
      int cpp;
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_err++;
         $display("FAIL R3 watchdog got %0d exp below 150000", cyc);
         finish_run();
      end
      if (!rst_n) begin
         m_lvl_q = 0; m_ph = 0; m_ext = 0; m_dbl = 0; m_run = 0; m_win = 0; m_err = 0;
         m_low = 'h50; m_dly = 'h50; m_wid = 0; m_cnt = 0; m_rem = 0;
      end else begin
         lvl = hsync_act_hi ? hsync_in : !hsync_in;
         edg = lvl && !m_lvl_q;
         cpp = m_dbl ? 2 : 1;
         pls = m_run && (m_cnt == m_dly * cpp) && !edg;
         if (edg) begin
            m_dly = m_ext * 256 + m_low;
            m_dbl = dbl_mode;
            m_wid = act_width;
            m_run = 1; m_cnt = 0; m_win = 0; m_err = 0;
         end else begin
            if (pls) begin
               m_run = 0;
               if (m_dbl && m_ph) m_err = 1;
            end else if (m_run) m_cnt++;
            if (pls && m_wid != 0) begin
               m_win = 1; m_rem = m_wid * cpp - 1;
            end else if (m_win) begin
               if (m_rem == 0) m_win = 0; else m_rem--;
            end
         end
         if (cfg_we) begin
            if (cfg_addr) m_ext = cfg_wdata[0];
            else          m_low = cfg_wdata;
         end
         m_lvl_q = lvl;
         m_ph = !m_ph;
      end
      #1;
      if (rst_n) begin
         lvl = hsync_act_hi ? hsync_in : !hsync_in;
         edg = lvl && !m_lvl_q;
         cpp = m_dbl ? 2 : 1;
         pls = m_run && (m_cnt == m_dly * cpp) && !edg;
         check("R3 sav_pulse", sav_pulse, pls);
         check("R9 active_win", active_win, m_win);
         check("R10 align_err", align_err, m_err);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input bit a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_dly(input int d);
      wr(1'b0, 8'(d));
      wr(1'b1, {7'b0, 1'(d >> 8)});
   endtask

   // returns clocks from edge drive to the sampled strobe
   task automatic run_line(input string tag, input int exp);
      int got;
      got = -1;
      @(negedge clk);
      hsync_in = hsync_act_hi;
      for (int i = 1; i <= 1200; i++) begin
         @(posedge clk); #1;
         if (sav_pulse) begin got = i; break; end
      end
      @(negedge clk);
      hsync_in = !hsync_act_hi;
      check(tag, got, exp);
   endtask

   task automatic win_count(input int n, output int hi, output bit err_first);
      hi = 0; err_first = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         if (active_win) hi++;
         if (i == 0) err_first = align_err;
      end
   endtask

   initial begin
      int hi;
      bit ea, eb, ec, e0;
      int got, npls;

      repeat (4) @(negedge clk);
      check("R1 reset sav_pulse", sav_pulse, 0);
      check("R1 reset active_win", active_win, 0);
      check("R1 reset align_err", align_err, 0);
      rst_n = 1'b1;

      // R1: default delay of 80 pixels
      run_line("R1 default latency", 81);
      win_count(5, hi, e0);
      check("R9 zero width no window", hi, 0);

      // R6: leaving the active level starts nothing
      set_dly(2);
      run_line("R6 rising active-high", 3);
      npls = 0;
      for (int i = 0; i < 10; i++) begin @(posedge clk); #1; if (sav_pulse) npls++; end
      check("R6 falling edge ignored", npls, 0);

      // R2: split delay, 0x105 = 261
      set_dly(261);
      run_line("R2 split delay latency", 262);
      wr(1'b1, 8'hFE);
      run_line("R2 ext upper bits ignored", 6);

      // R8: mid-line write deferred
      set_dly(10);
      fork
         run_line("R8 old delay kept", 11);
         begin repeat (4) @(negedge clk); wr(1'b0, 8'd3); end
      join
      run_line("R8 new delay next line", 4);

      // R3 / R9 single-rate window
      act_width = 10'd5;
      set_dly(6);
      run_line("R3 single-rate latency", 7);
      win_count(8, hi, e0);
      check("R9 window single-rate", hi, 5);
      check("R10 no error single-rate", e0, 0);

      // R4 / R9 / R10 double-rate
      dbl_mode = 1'b1;
      set_dly(7);
      run_line("R4 double-rate latency A", 15);
      win_count(12, hi, ea);
      check("R9 window double-rate", hi, 10);
      run_line("R4 double-rate latency B", 15);
      win_count(12, hi, eb);
      @(negedge clk);
      run_line("R4 double-rate latency C", 15);
      win_count(12, hi, ec);
      check("R10 phase-dependent error", int'((ea != eb) || (eb != ec)), 1);

      // R5: zero delay
      set_dly(0);
      run_line("R5 zero delay double-rate", 1);
      dbl_mode = 1'b0;
      run_line("R5 zero delay single-rate", 1);

      // R7: restart mid-count
      set_dly(20);
      @(negedge clk); hsync_in = 1'b1;
      repeat (5) @(negedge clk); hsync_in = 1'b0;
      repeat (3) @(negedge clk); hsync_in = 1'b1;
      got = -1;
      for (int i = 1; i <= 100; i++) begin
         @(posedge clk); #1;
         if (sav_pulse) begin got = i; break; end
      end
      @(negedge clk); hsync_in = 1'b0;
      check("R7 restart latency", got, 21);

      // R6: active-low sync
      @(negedge clk); hsync_in = 1'b1; hsync_act_hi = 1'b0;
      set_dly(4);
      run_line("R6 falling active-low", 5);

      // R11: edge clears open window
      @(negedge clk); hsync_act_hi = 1'b1; hsync_in = 1'b0;
      act_width = 10'd50;
      set_dly(2);
      run_line("R11 setup latency", 3);
      repeat (3) @(posedge clk);
      @(negedge clk); hsync_in = 1'b1;
      @(posedge clk); #1;
      check("R11 window closed by edge", active_win, 0);
      @(negedge clk); hsync_in = 1'b0;
      repeat (120) @(negedge clk);

      finish_run();
   end

endmodule